// File: doc/BRIEF.md
# Packed Element Issue Sequencer

This block sits just after instruction decode. It takes one instruction that looks scalar, with a destination and two source operands, and expands it into a series of per-element micro-operations. Each operand carries its own register span (how many consecutive registers it covers) and its own element-width code. Every register of width `REG_W` holds `REG_W / element_width` packed sub-words. Element numbers run through the sub-words of the base register first and then move on to the next register.

For every element that is enabled, the sequencer gives, per operand, the real register number and the least significant bit of that element inside the register. The destination's span times its sub-words per register sets the element count. A global length cuts the count short, and a per-element predicate bit can suppress single elements. Enabled micro-ops leave through a valid/ready port, one per cycle at most. An instruction whose operands are all single-register and full-width passes through as one micro-op. A reserved width code is reported and issues nothing. The ALU and register file are outside the block.

Top module: `pes_sequencer`

## Requirements
- R1: Width codes per operand are 000 full register, 001 8-bit, 010 16-bit, 011 32-bit, 100 64-bit, 101 128-bit. If any operand uses 110 or 111, `cfg_illegal` is high for exactly the cycle after acceptance, no micro-op issues, and `in_ready` stays high.
- R2: Sub-words per register are `REG_W` divided by the element width. A width larger than the register behaves as the full register, which gives one element per register.
- R3: The element count is the destination span times the destination sub-words per register. A span of 0 counts as 1.
- R4: For element i of a vector operand, the register is (base + i / subwords) modulo `NUM_REGS` and the LSB is (i mod subwords) * element_width.
- R5: An element whose index is at or above `in_vlen` is not issued. A `in_vlen` of 0 on a vector instruction issues nothing.
- R6: Element i issues only if bit i of `in_pred` is 1. Disabled elements produce no micro-op.
- R7: If all three operands have span 1 and code 000, exactly one micro-op issues. It has element 0, the base registers, every LSB 0 and `uop_scalar`=1, whatever `in_vlen` and `in_pred` hold.
- R8: A source with span 1 and code 000 inside a vector instruction is broadcast. It gives its base register and LSB 0 for every element.
- R9: While `uop_valid` is high and `uop_ready` is low, the micro-op and all its fields stay unchanged. Issue resumes at the same element.
- R10: After reset `in_ready`=1, `uop_valid`=0 and `cfg_illegal`=0. `in_ready` is low while an instruction is being expanded and returns high after its last element.
- R11: Micro-ops of one instruction leave in strictly ascending element order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction taken when valid |
| in_dst_reg | input | RIDX_W | Destination base register |
| in_src1_reg | input | RIDX_W | Source 1 base register |
| in_src2_reg | input | RIDX_W | Source 2 base register |
| in_dst_span | input | SPAN_W | Destination register span |
| in_src1_span | input | SPAN_W | Source 1 register span |
| in_src2_span | input | SPAN_W | Source 2 register span |
| in_dst_wcode | input | 3 | Destination width code |
| in_src1_wcode | input | 3 | Source 1 width code |
| in_src2_wcode | input | 3 | Source 2 width code |
| in_vlen | input | CNT_W | Global element length |
| in_pred | input | MAX_ELEM | Per-element enable bits |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Downstream queue accepts |
| uop_elem | output | CNT_W | Element index |
| uop_dst_reg | output | RIDX_W | Destination real register |
| uop_dst_lsb | output | OFS_W | Destination element LSB |
| uop_src1_reg | output | RIDX_W | Source 1 real register |
| uop_src1_lsb | output | OFS_W | Source 1 element LSB |
| uop_src2_reg | output | RIDX_W | Source 2 real register |
| uop_src2_lsb | output | OFS_W | Source 2 element LSB |
| uop_ew_log | output | 3 | log2 of destination element width in bits |
| uop_scalar | output | 1 | Pass-through micro-op |
| cfg_illegal | output | 1 | Reserved width code seen |

## Verification
The bench sweeps every legal destination width, span and global length, including lengths beyond the element count. It uses several predicate patterns, a source whose register walk wraps past the last register, and a broadcast source. A design that divides where it should take a modulus would put elements in the wrong register or sub-word. A design that ignores the length or predicate would issue too many micro-ops. One that advances under back-pressure would skip or duplicate an element. Directed cases cover the pass-through with a zero length and empty predicate, span 0, widths wider than the register, and reserved codes on each operand. A design that broke these would issue nothing, loop, or accept the bad configuration.

// File: rtl/pes_pkg.sv
package pes_pkg;

    localparam int unsigned NUM_OPND = 3;   // destination, source 1, source 2
    localparam int unsigned LOG_W    = 3;   // holds log2 of up to 128-bit elements

    typedef enum logic [2:0] {
        WC_FULL = 3'b000,
        WC_B8   = 3'b001,
        WC_B16  = 3'b010,
        WC_B32  = 3'b011,
        WC_B64  = 3'b100,
        WC_B128 = 3'b101,
        WC_RSV6 = 3'b110,
        WC_RSV7 = 3'b111
    } wcode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

endpackage

// File: rtl/pes_width_decode.sv
module pes_width_decode
    import pes_pkg::*;
#(
    parameter int unsigned REG_LOG = 5
) (
    input  logic [2:0]       wcode,
    output logic             illegal,
    output logic [LOG_W-1:0] ew_log,
    output logic [LOG_W-1:0] sub_log
);

    logic [LOG_W-1:0] raw_log;

    always_comb begin
        illegal = 1'b0;
        case (wcode_e'(wcode))
            WC_FULL: raw_log = LOG_W'(REG_LOG);
            WC_B8:   raw_log = LOG_W'(3);
            WC_B16:  raw_log = LOG_W'(4);
            WC_B32:  raw_log = LOG_W'(5);
            WC_B64:  raw_log = LOG_W'(6);
            WC_B128: raw_log = LOG_W'(7);
            default: begin
                raw_log = LOG_W'(REG_LOG);
                illegal = 1'b1;
            end
        endcase
        // an element wider than the register collapses to the full register
        ew_log  = (raw_log > LOG_W'(REG_LOG)) ? LOG_W'(REG_LOG) : raw_log;
        sub_log = LOG_W'(REG_LOG) - ew_log;
    end

endmodule

// File: rtl/pes_elem_addr.sv
module pes_elem_addr
    import pes_pkg::*;
#(
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned RIDX_W = 5,
    parameter int unsigned OFS_W  = 5
) (
    input  logic [CNT_W-1:0]  elem,
    input  logic [RIDX_W-1:0] base,
    input  logic [LOG_W-1:0]  sub_log,
    input  logic [LOG_W-1:0]  ew_log,
    input  logic              bcast,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [OFS_W-1:0]  lsb
);

    logic [CNT_W-1:0] reg_step;
    logic [CNT_W-1:0] slot;

    always_comb begin
        reg_step = elem >> sub_log;
        slot     = elem & ~({CNT_W{1'b1}} << sub_log);
        if (bcast) begin
            reg_idx = base;
            lsb     = '0;
        end else begin
            reg_idx = base + RIDX_W'(reg_step);
            lsb     = OFS_W'(slot) << ew_log;
        end
    end

endmodule

// File: rtl/pes_sequencer.sv
module pes_sequencer
    import pes_pkg::*;
#(
    parameter  int unsigned REG_W     = 32,
    parameter  int unsigned NUM_REGS  = 32,
    parameter  int unsigned MAX_SPAN  = 4,
    localparam int unsigned REG_LOG   = $clog2(REG_W),
    localparam int unsigned RIDX_W    = $clog2(NUM_REGS),
    localparam int unsigned SPAN_W    = $clog2(MAX_SPAN + 1),
    localparam int unsigned MAX_ELEM  = MAX_SPAN * REG_W / 8,
    localparam int unsigned CNT_W     = $clog2(MAX_ELEM + 1),
    localparam int unsigned OFS_W     = REG_LOG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [RIDX_W-1:0]   in_dst_reg,
    input  logic [RIDX_W-1:0]   in_src1_reg,
    input  logic [RIDX_W-1:0]   in_src2_reg,
    input  logic [SPAN_W-1:0]   in_dst_span,
    input  logic [SPAN_W-1:0]   in_src1_span,
    input  logic [SPAN_W-1:0]   in_src2_span,
    input  logic [2:0]          in_dst_wcode,
    input  logic [2:0]          in_src1_wcode,
    input  logic [2:0]          in_src2_wcode,
    input  logic [CNT_W-1:0]    in_vlen,
    input  logic [MAX_ELEM-1:0] in_pred,
    output logic                uop_valid,
    input  logic                uop_ready,
    output logic [CNT_W-1:0]    uop_elem,
    output logic [RIDX_W-1:0]   uop_dst_reg,
    output logic [OFS_W-1:0]    uop_dst_lsb,
    output logic [RIDX_W-1:0]   uop_src1_reg,
    output logic [OFS_W-1:0]    uop_src1_lsb,
    output logic [RIDX_W-1:0]   uop_src2_reg,
    output logic [OFS_W-1:0]    uop_src2_lsb,
    output logic [LOG_W-1:0]    uop_ew_log,
    output logic                uop_scalar,
    output logic                cfg_illegal
);

    typedef struct packed {
        seq_st_e                              st;
        logic [CNT_W-1:0]                     idx;
        logic [CNT_W-1:0]                     last;
        logic                                 scalar;
        logic                                 illegal;
        logic [MAX_ELEM-1:0]                  pred;
        logic [NUM_OPND-1:0][RIDX_W-1:0]      base;
        logic [NUM_OPND-1:0][LOG_W-1:0]       sub_log;
        logic [NUM_OPND-1:0][LOG_W-1:0]       ew_log;
        logic [NUM_OPND-1:0]                  bcast;
    } seq_t;

    seq_t s_d, s_q;

    // ---------------- operand decode on the offered instruction ----------
    logic [NUM_OPND-1:0][RIDX_W-1:0] in_base;
    logic [NUM_OPND-1:0][SPAN_W-1:0] in_span;
    logic [NUM_OPND-1:0][2:0]        in_wc;
    logic [NUM_OPND-1:0]             dec_ill;
    logic [NUM_OPND-1:0][LOG_W-1:0]  dec_ew;
    logic [NUM_OPND-1:0][LOG_W-1:0]  dec_sub;
    logic [NUM_OPND-1:0][SPAN_W-1:0] span_eff;
    logic [NUM_OPND-1:0]             in_bcast;

    assign in_base = {in_src2_reg,   in_src1_reg,   in_dst_reg};
    assign in_span = {in_src2_span,  in_src1_span,  in_dst_span};
    assign in_wc   = {in_src2_wcode, in_src1_wcode, in_dst_wcode};

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd_dec
        pes_width_decode #(
            .REG_LOG (REG_LOG)
        ) u_dec (
            .wcode   (in_wc[g]),
            .illegal (dec_ill[g]),
            .ew_log  (dec_ew[g]),
            .sub_log (dec_sub[g])
        );
        assign span_eff[g] = (in_span[g] == '0) ? SPAN_W'(1) : in_span[g];
        assign in_bcast[g] = (span_eff[g] == SPAN_W'(1)) && (in_wc[g] == WC_FULL);
    end

    // ---------------- element count and length cut-off --------------------
    logic [CNT_W:0] dst_count;
    logic [CNT_W:0] vlen_ext;
    logic [CNT_W:0] in_limit;
    logic           in_scalar;

    always_comb begin
        in_scalar = &in_bcast;
        dst_count = (CNT_W + 1)'(span_eff[0]) << dec_sub[0];
        vlen_ext  = {1'b0, in_vlen};
        if (in_scalar) begin
            in_limit = (CNT_W + 1)'(1);
        end else if (dst_count < vlen_ext) begin
            in_limit = dst_count;
        end else begin
            in_limit = vlen_ext;
        end
    end

    // ---------------- per-operand address generation ----------------------
    logic [NUM_OPND-1:0][RIDX_W-1:0] addr_reg;
    logic [NUM_OPND-1:0][OFS_W-1:0]  addr_lsb;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd_addr
        pes_elem_addr #(
            .CNT_W  (CNT_W),
            .RIDX_W (RIDX_W),
            .OFS_W  (OFS_W)
        ) u_addr (
            .elem    (s_q.idx),
            .base    (s_q.base[g]),
            .sub_log (s_q.sub_log[g]),
            .ew_log  (s_q.ew_log[g]),
            .bcast   (s_q.bcast[g]),
            .reg_idx (addr_reg[g]),
            .lsb     (addr_lsb[g])
        );
    end

    // ---------------- element enable and next state ------------------------
    logic [MAX_ELEM-1:0] pred_sh;
    logic                elem_en;

    always_comb begin
        pred_sh = s_q.pred >> s_q.idx;
        elem_en = s_q.scalar || pred_sh[0];
    end

    always_comb begin
        s_d         = s_q;
        s_d.illegal = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (|dec_ill) begin
                        s_d.illegal = 1'b1;
                    end else if (in_limit != '0) begin
                        s_d.st      = ST_RUN;
                        s_d.idx     = '0;
                        s_d.last    = CNT_W'(in_limit - (CNT_W + 1)'(1));
                        s_d.scalar  = in_scalar;
                        s_d.pred    = in_pred;
                        s_d.base    = in_base;
                        s_d.sub_log = dec_sub;
                        s_d.ew_log  = dec_ew;
                        s_d.bcast   = in_bcast;
                    end
                end
            end
            default: begin
                if (!elem_en || uop_ready) begin
                    if (s_q.idx == s_q.last) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // ---------------- outputs ----------------------------------------------
    assign in_ready     = (s_q.st == ST_IDLE);
    assign uop_valid    = (s_q.st == ST_RUN) && elem_en;
    assign uop_elem     = s_q.idx;
    assign uop_dst_reg  = addr_reg[0];
    assign uop_dst_lsb  = addr_lsb[0];
    assign uop_src1_reg = addr_reg[1];
    assign uop_src1_lsb = addr_lsb[1];
    assign uop_src2_reg = addr_reg[2];
    assign uop_src2_lsb = addr_lsb[2];
    assign uop_ew_log   = s_q.ew_log[0];
    assign uop_scalar   = s_q.scalar;
    assign cfg_illegal  = s_q.illegal;

endmodule

// File: rtl/pes_sequencer_chk.sv
module pes_sequencer_chk #(
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned RIDX_W = 5,
    parameter int unsigned OFS_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              uop_valid,
    input logic              uop_ready,
    input logic [CNT_W-1:0]  uop_elem,
    input logic [RIDX_W-1:0] uop_dst_reg,
    input logic [OFS_W-1:0]  uop_dst_lsb,
    input logic [RIDX_W-1:0] uop_src1_reg,
    input logic [OFS_W-1:0]  uop_src1_lsb,
    input logic [RIDX_W-1:0] uop_src2_reg,
    input logic [OFS_W-1:0]  uop_src2_lsb,
    input logic [2:0]        uop_ew_log,
    input logic              uop_scalar,
    input logic              cfg_illegal
);

    a_r1_illegal_issues_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_illegal |-> (in_ready && !uop_valid));

    a_r4_lsb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> (((uop_dst_lsb >> uop_ew_log) << uop_ew_log) == uop_dst_lsb));

    a_r7_scalar_single: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_scalar) |-> (uop_elem == '0 && uop_dst_lsb == '0
                                       && uop_src1_lsb == '0 && uop_src2_lsb == '0));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_elem)
            && $stable(uop_dst_reg) && $stable(uop_dst_lsb)
            && $stable(uop_src1_reg) && $stable(uop_src1_lsb)
            && $stable(uop_src2_reg) && $stable(uop_src2_lsb)));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !in_ready);

    a_r11_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready) |=> (!uop_valid || uop_elem > $past(uop_elem)));

endmodule

bind pes_sequencer pes_sequencer_chk #(
    .CNT_W  (CNT_W),
    .RIDX_W (RIDX_W),
    .OFS_W  (OFS_W)
) i_chk (.*);

// File: tb/test_pes_sequencer.sv
module test_pes_sequencer;

    localparam int RW    = 32;
    localparam int RLOG  = 5;
    localparam int NREG  = 32;
    localparam int MELEM = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  in_dst_reg = '0, in_src1_reg = '0, in_src2_reg = '0;
    logic [2:0]  in_dst_span = '0, in_src1_span = '0, in_src2_span = '0;
    logic [2:0]  in_dst_wcode = '0, in_src1_wcode = '0, in_src2_wcode = '0;
    logic [4:0]  in_vlen = '0;
    logic [15:0] in_pred = '0;
    logic        uop_valid;
    logic        uop_ready = 1'b0;
    logic [4:0]  uop_elem;
    logic [4:0]  uop_dst_reg, uop_src1_reg, uop_src2_reg;
    logic [4:0]  uop_dst_lsb, uop_src1_lsb, uop_src2_lsb;
    logic [2:0]  uop_ew_log;
    logic        uop_scalar;
    logic        cfg_illegal;

    pes_sequencer i_pes_sequencer (.*);

    always #10 clk = ~clk;   // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int stall_mode = 0;
    int stall_bad = 0;
    int obs_n = 0;
    logic [35:0] obs_key [64];
    logic [35:0] exp_key [64];
    int exp_n;
    logic        prev_hold = 1'b0;
    logic [35:0] prev_key = '0;

    function automatic logic [35:0] cur_key();
        return {uop_elem, uop_dst_reg, uop_dst_lsb, uop_src1_reg, uop_src1_lsb,
                uop_src2_reg, uop_src2_lsb, uop_scalar};
    endfunction

    // collector: drives ready and records accepted micro-ops away from the edge
    always @(negedge clk) begin
        cyc++;
        if (prev_hold && !(uop_valid && cur_key() == prev_key)) stall_bad++;
        uop_ready = (stall_mode == 0) || (cyc % 3 != 1);
        if (uop_valid && uop_ready && obs_n < 64) begin
            obs_key[obs_n] = cur_key();
            obs_n++;
        end
        prev_hold = uop_valid && !uop_ready;
        prev_key  = cur_key();
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            finish_run();
        end
    end

    task automatic check(input logic ok, input string req, input logic [35:0] act,
                         input logic [35:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, expv);
        end
    endtask

    function automatic int ew_log_of(input int code);
        int l;
        l = (code == 0) ? RLOG : code + 2;
        return (l > RLOG) ? RLOG : l;
    endfunction

    task automatic map_opnd(input int base, input int span, input int code, input int i,
                            output int r, output int l);
        int ew, sub;
        if (span <= 1 && code == 0) begin
            r = base; l = 0;
        end else begin
            ew  = ew_log_of(code);
            sub = RLOG - ew;
            r   = (base + (i >> sub)) % NREG;
            l   = (i % (1 << sub)) << ew;
        end
    endtask

    task automatic run_op(input int db, input int ds, input int dw,
                          input int ab, input int as, input int aw,
                          input int bb, input int bs, input int bw,
                          input int vl, input logic [15:0] pr, input int stall,
                          input string req);
        int n, dr, dl, ar, al, br, bl;
        logic ill_exp, ill_seen, rdy_seen, scal;
        ill_exp = (dw >= 6) || (aw >= 6) || (bw >= 6);
        scal = (ds <= 1 && dw == 0) && (as <= 1 && aw == 0) && (bs <= 1 && bw == 0);
        exp_n = 0;
        if (!ill_exp) begin
            if (scal) begin
                exp_key[0] = {5'd0, 5'(db), 5'd0, 5'(ab), 5'd0, 5'(bb), 5'd0, 1'b1};
                exp_n = 1;
            end else begin
                n = ((ds == 0) ? 1 : ds) << (RLOG - ew_log_of(dw));
                for (int i = 0; i < n; i++) begin
                    if (i < vl && pr[i]) begin
                        map_opnd(db, ds, dw, i, dr, dl);
                        map_opnd(ab, as, aw, i, ar, al);
                        map_opnd(bb, bs, bw, i, br, bl);
                        exp_key[exp_n] = {5'(i), 5'(dr), 5'(dl), 5'(ar), 5'(al),
                                          5'(br), 5'(bl), 1'b0};
                        exp_n++;
                    end
                end
            end
        end
        @(negedge clk);
        obs_n = 0;
        stall_mode = stall;
        in_dst_reg = 5'(db);  in_dst_span = 3'(ds);  in_dst_wcode = 3'(dw);
        in_src1_reg = 5'(ab); in_src1_span = 3'(as); in_src1_wcode = 3'(aw);
        in_src2_reg = 5'(bb); in_src2_span = 3'(bs); in_src2_wcode = 3'(bw);
        in_vlen = 5'(vl); in_pred = pr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        ill_seen = cfg_illegal;
        rdy_seen = in_ready;
        while (!in_ready) @(negedge clk);
        check(ill_seen == ill_exp, {req, " R1 illegal flag"}, 36'(ill_seen), 36'(ill_exp));
        if (ill_exp)
            check(rdy_seen == 1'b1, "R1 ready kept", 36'(rdy_seen), 36'd1);
        else if (exp_n > 0)
            check(rdy_seen == 1'b0, "R10 busy", 36'(rdy_seen), 36'd0);
        check(obs_n == exp_n, {req, " count"}, 36'(obs_n), 36'(exp_n));
        for (int k = 0; k < exp_n && k < obs_n; k++)
            check(obs_key[k] == exp_key[k], {req, " R11 element"}, obs_key[k], exp_key[k]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(in_ready == 1'b1 && uop_valid == 1'b0 && cfg_illegal == 1'b0, "R10 reset",
              {33'd0, in_ready, uop_valid, cfg_illegal}, 36'b100);

        // R7 pass-through ignores length and predicate
        run_op(3, 1, 0, 7, 1, 0, 9, 1, 0, 0, 16'h0000, 0, "R7");
        run_op(12, 0, 0, 1, 1, 0, 31, 0, 0, 5, 16'h0000, 1, "R7 R3");

        // R4 default width, span 3 at r4 walks r4, r5, r6
        run_op(4, 3, 0, 10, 3, 0, 2, 1, 0, 16, 16'hFFFF, 0, "R4 R8");
        check(obs_n == 3 && obs_key[2][30:26] == 5'd6, "R4 r6 third", 36'(obs_key[2][30:26]), 36'd6);

        // R5 16-bit, span 3, length 5: elements 0..4, last one in r6 low half
        run_op(4, 3, 2, 20, 3, 2, 0, 1, 0, 5, 16'hFFFF, 1, "R5");
        check(obs_n == 5 && obs_key[4][35:21] == {5'd4, 5'd6, 5'd0}, "R5 fifth",
              36'(obs_key[4][35:21]), 36'({5'd4, 5'd6, 5'd0}));

        // R2 widths wider than the register act as full register
        run_op(8, 2, 4, 16, 2, 5, 0, 1, 0, 16, 16'hFFFF, 0, "R2");
        check(obs_n == 2, "R2 two elements", 36'(obs_n), 36'd2);

        // R3 span 0 counts as 1; R5 zero length issues nothing
        run_op(2, 0, 1, 5, 0, 1, 6, 1, 0, 16, 16'hFFFF, 0, "R3");
        run_op(2, 2, 1, 5, 2, 1, 6, 1, 0, 0, 16'hFFFF, 0, "R5 zero");

        // R1 reserved codes on each operand
        run_op(1, 1, 6, 2, 1, 0, 3, 1, 0, 16, 16'hFFFF, 0, "R1 dst");
        run_op(1, 2, 1, 2, 1, 7, 3, 1, 0, 16, 16'hFFFF, 0, "R1 src1");
        run_op(1, 2, 1, 2, 1, 0, 3, 2, 6, 16, 16'hFFFF, 1, "R1 src2");

        // sweep: widths, spans, lengths, predicates, wrap, broadcast, stalls
        for (int w = 1; w <= 3; w++) begin
            for (int s = 1; s <= 4; s++) begin
                for (int v = 0; v <= ((s << (RLOG - ew_log_of(w))) + 1) && v < 32; v++) begin
                    run_op(s * 3, s, w, 30, 4, 1, 17, 1, 0, v, 16'hFFFF, v % 2,
                           "R2 R3 R4 R5 R8 R9");
                    run_op(s * 5, s, w, 28, s, w, 9, 1, 0, v, 16'h5A3C ^ 16'(v * 257), (v + 1) % 2,
                           "R4 R6 R9");
                end
            end
        end

        check(stall_bad == 0, "R9 held under stall", 36'(stall_bad), 36'd0);
        finish_run();
    end

endmodule